// File: doc/BRIEF.md
# Clock Calendar Update Engine

The block keeps the time of day and the calendar: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A one-cycle 1 Hz tick from an external prescaler starts an update. The block raises an update-in-progress flag at once. After a fixed lead of `LEAD_CYCLES` clock cycles it advances the time by one second, drops the flag and pulses an update-done strobe. Month lengths, leap years and the two daylight-saving jumps are handled during that advance.

The counters are kept internally in plain binary with a 24-hour clock. The host sees a separate buffer of seven bytes. After each update the buffer is reloaded from the new time, encoded in the format the host has selected, unless the host holds the inhibit input high. A host write goes both to the addressed buffer byte and to the matching internal counter. The counter value is decoded with the format in force at the time of the write.

Top module: `rtc_time_engine`

## Requirements
- R1: After reset the buffer reads 00,00,00,01,01,01,00 at addresses 0 to 6 (second, minute, hour, weekday with 1 = Sunday, day of month, month, year), address 7 reads 00, and `uip` and `upd_done` are low.
- R2: A tick updates the time LEAD_CYCLES clock edges after the edge that samples it. The seconds count 0..59 and carry into the minutes; the minutes count 0..59 and carry into the hours.
- R3: Without inhibit, `uip` is high from the edge that samples the tick until the update edge. At that edge `uip` falls and `upd_done` goes high for exactly one cycle.
- R4: With `fmt_bin` = 1, every buffer byte holds its plain binary value. With `fmt_bin` = 0 it holds two BCD digits, tens in bits 7..4.
- R5: With `hour24` = 1, the hours count 0..23. Leaving 23:59:59 gives 00:00:00, advances the day of month, and steps the weekday 1..7 with 7 wrapping to 1.
- R6: With `hour24` = 0, the hour byte holds 1..12 in bits 6..0 and bit 7 is set for PM. 11:59:59 AM becomes 12 PM (BCD 92h), 12:59:59 PM becomes 1 PM (81h), and 11:59:59 PM becomes 12 AM (12h).
- R7: April, June, September and November end after day 30, and the other months except February end after day 31. December wraps to January and year 99 wraps to 00.
- R8: February has 29 days when the year value is a multiple of 4 and 28 days otherwise.
- R9: While `inhibit` is high, the buffer keeps its contents across updates but the internal time still advances. The first update after `inhibit` falls shows the advanced time.
- R10: While `inhibit` is high, `uip` stays low even during a pending update.
- R11: With `dst_en` = 1, on a Sunday in April with day of month 1..7, 01:59:59 is followed by 03:00:00.
- R12: With `dst_en` = 1, on a Sunday in October with day of month 25..31, the first pass beyond 01:59:59 returns to 01:00:00. A second pass on the same day goes on to 02:00:00.
- R13: With `dst_en` = 0, the April Sunday case advances 01:59:59 to 02:00:00.
- R14: A host write is readable from the buffer on the next cycle. The internal counter takes the decoded value, so a BCD write of 45h to the seconds followed by a switch to binary and an update reads 2Eh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 1 Hz update request |
| fmt_bin | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hour24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| dst_en | input | 1 | Enables the daylight-saving jumps |
| inhibit | input | 1 | Freezes the host buffer |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address (0..6) |
| wr_data | input | 8 | Host write byte |
| rd_addr | input | 3 | Host read address |
| rd_data | output | 8 | Buffer byte at rd_addr (combinational) |
| uip | output | 1 | Update in progress |
| upd_done | output | 1 | One-cycle pulse at the end of an update |

## Verification
A wrong internal counter appears in the buffer on the first update that is not inhibited. It is read back LEAD_CYCLES edges after the tick, so each directed case checks the bytes right after that update. Carry faults appear only at the boundaries, so the cases start one second before each rollover: minute, midnight, 12-hour noon and midnight, month ends, leap February, year wrap and both daylight-saving Sundays. A stale daylight-saving flag shows only on the second October pass, which is why that pass is checked too. The inhibit case shows a frozen buffer first and then the internal time that advanced underneath it.

// File: rtl/rtc_time_engine.sv
module rtc_time_engine #(
  parameter int LEAD_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       fmt_bin,
  input  logic       hour24,
  input  logic       dst_en,
  input  logic       inhibit,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       uip,
  output logic       upd_done
);
  localparam int CW = $clog2(LEAD_CYCLES + 1);

  logic [7:0] sec, mnt, hr, wday, mday, mon, yr;
  logic       fell_back;
  logic [7:0] ub [7];
  logic [CW-1:0] cnt;
  logic       busy, fire;

  logic [7:0] n_sec, n_mnt, n_hr, n_wday, n_mday, n_mon, n_yr, mlen;
  logic       n_fb, spring, fall;

  function automatic logic [7:0] enc(input logic [7:0] v, input logic bin);
    logic [7:0] t, o;
    t = v / 8'd10;
    o = v - t * 8'd10;
    return bin ? v : {t[3:0], o[3:0]};
  endfunction

  function automatic logic [7:0] dec(input logic [7:0] d, input logic bin);
    return bin ? d : ({4'd0, d[7:4]} * 8'd10 + {4'd0, d[3:0]});
  endfunction

  function automatic logic [7:0] enc_hr(input logic [7:0] h, input logic bin, input logic m24);
    logic [7:0] h12, e;
    h12 = (h == 8'd0) ? 8'd12 : (h > 8'd12 ? h - 8'd12 : h);
    e = enc(h12, bin);
    return m24 ? enc(h, bin) : {(h >= 8'd12), e[6:0]};
  endfunction

  function automatic logic [7:0] dec_hr(input logic [7:0] d, input logic bin, input logic m24);
    logic [7:0] v;
    v = dec({1'b0, d[6:0]}, bin);
    if (m24) return dec(d, bin);
    if (v == 8'd12) return d[7] ? 8'd12 : 8'd0;
    return d[7] ? v + 8'd12 : v;
  endfunction

  assign busy     = (cnt != '0);
  assign fire     = (cnt == CW'(1));
  assign uip      = busy & ~inhibit;
  assign rd_data  = (rd_addr == 3'd7) ? 8'h00 : ub[rd_addr];

  always_comb begin
    case (mon)
      8'd2:                     mlen = (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:  mlen = 8'd30;
      default:                  mlen = 8'd31;
    endcase
  end

  assign spring = dst_en && mon == 8'd4  && wday == 8'd1 && mday <= 8'd7  && hr == 8'd1;
  assign fall   = dst_en && mon == 8'd10 && wday == 8'd1 && mday >= 8'd25 && hr == 8'd1 && !fell_back;

  always_comb begin
    n_sec = sec + 8'd1; n_mnt = mnt; n_hr = hr; n_wday = wday;
    n_mday = mday; n_mon = mon; n_yr = yr; n_fb = fell_back;
    if (sec == 8'd59) begin
      n_sec = 8'd0;
      n_mnt = mnt + 8'd1;
      if (mnt == 8'd59) begin
        n_mnt = 8'd0;
        n_hr  = hr + 8'd1;
        if (spring) n_hr = 8'd3;
        else if (fall) begin
          n_hr = 8'd1;
          n_fb = 1'b1;
        end else if (hr == 8'd23) begin
          n_hr   = 8'd0;
          n_fb   = 1'b0;
          n_wday = (wday == 8'd7) ? 8'd1 : wday + 8'd1;
          n_mday = mday + 8'd1;
          if (mday >= mlen) begin
            n_mday = 8'd1;
            n_mon  = mon + 8'd1;
            if (mon == 8'd12) begin
              n_mon = 8'd1;
              n_yr  = (yr == 8'd99) ? 8'd0 : yr + 8'd1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
      upd_done <= 1'b0;
    end else begin
      upd_done <= fire;
      if (busy)      cnt <= cnt - CW'(1);
      else if (tick) cnt <= CW'(LEADFIX);
    end
  end
  localparam int LEADFIX = (LEAD_CYCLES < 1) ? 1 : LEAD_CYCLES;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec <= 8'd0; mnt <= 8'd0; hr <= 8'd0; wday <= 8'd1;
      mday <= 8'd1; mon <= 8'd1; yr <= 8'd0; fell_back <= 1'b0;
      ub[0] <= 8'h00; ub[1] <= 8'h00; ub[2] <= 8'h00; ub[3] <= 8'h01;
      ub[4] <= 8'h01; ub[5] <= 8'h01; ub[6] <= 8'h00;
    end else begin
      if (fire) begin
        sec <= n_sec; mnt <= n_mnt; hr <= n_hr; wday <= n_wday;
        mday <= n_mday; mon <= n_mon; yr <= n_yr; fell_back <= n_fb;
        if (!inhibit) begin
          ub[0] <= enc(n_sec, fmt_bin);
          ub[1] <= enc(n_mnt, fmt_bin);
          ub[2] <= enc_hr(n_hr, fmt_bin, hour24);
          ub[3] <= enc(n_wday, fmt_bin);
          ub[4] <= enc(n_mday, fmt_bin);
          ub[5] <= enc(n_mon, fmt_bin);
          ub[6] <= enc(n_yr, fmt_bin);
        end
      end
      if (wr_en && wr_addr != 3'd7) begin
        ub[wr_addr] <= wr_data;
        case (wr_addr)
          3'd0:    sec  <= dec(wr_data, fmt_bin);
          3'd1:    mnt  <= dec(wr_data, fmt_bin);
          3'd2:    hr   <= dec_hr(wr_data, fmt_bin, hour24);
          3'd3:    wday <= dec(wr_data, fmt_bin);
          3'd4:    mday <= dec(wr_data, fmt_bin);
          3'd5:    mon  <= dec(wr_data, fmt_bin);
          default: yr   <= dec(wr_data, fmt_bin);
        endcase
      end
    end
  end

  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(upd_done) |-> $past(busy));

  // R3
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !upd_done);

  // R2
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> (sec < 8'd60 || $stable(sec)));

  // R2
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !wr_en) |=> $stable(sec));

  // R9
  buf_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !wr_en) |=> $stable(ub[0]));

  // R5
  cal_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !wr_en) |=> (hr < 8'd24 && wday >= 8'd1 && wday <= 8'd7 && mon >= 8'd1 && mon <= 8'd12));
endmodule

// File: tb/test_rtc_time_engine.sv
module test_rtc_time_engine;
  localparam int LEAD = 4;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic fmt_bin = 1'b0, hour24 = 1'b1, dst_en = 1'b0, inhibit = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0, rd_data;
  logic uip, upd_done;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  rtc_time_engine #(.LEAD_CYCLES(LEAD)) i_rtc_time_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fmt_bin(fmt_bin), .hour24(hour24),
    .dst_en(dst_en), .inhibit(inhibit), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .uip(uip),
    .upd_done(upd_done));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input string tag, input logic [7:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_hms(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
  endtask

  task automatic set_date(input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
    wr(3'd3, w); wr(3'd4, d); wr(3'd5, mo); wr(3'd6, y);
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (LEAD) @(negedge clk);
  endtask

  task automatic t_reset();
    rd(3'd0, "R1 sec", 8'h00); rd(3'd1, "R1 min", 8'h00); rd(3'd2, "R1 hour", 8'h00);
    rd(3'd3, "R1 wday", 8'h01); rd(3'd4, "R1 mday", 8'h01); rd(3'd5, "R1 mon", 8'h01);
    rd(3'd6, "R1 year", 8'h00); rd(3'd7, "R1 addr7", 8'h00);
    chk("R1 uip", {7'd0, uip}, 8'h00); chk("R1 done", {7'd0, upd_done}, 8'h00);
  endtask

  task automatic t_strobes();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R3 uip high", {7'd0, uip}, 8'h01);
    chk("R3 done low", {7'd0, upd_done}, 8'h00);
    repeat (LEAD - 1) @(negedge clk);
    chk("R3 uip before update", {7'd0, uip}, 8'h01);
    rd(3'd0, "R2 sec not yet", 8'h00);
    @(negedge clk);
    chk("R3 uip fall", {7'd0, uip}, 8'h00);
    chk("R3 done pulse", {7'd0, upd_done}, 8'h01);
    rd(3'd0, "R2 sec advanced", 8'h01);
    @(negedge clk);
    chk("R3 done single", {7'd0, upd_done}, 8'h00);
  endtask

  task automatic t_carry();
    hour24 = 1'b1; fmt_bin = 1'b0;
    set_hms(8'h10, 8'h59, 8'h59);
    do_tick();
    rd(3'd0, "R2 sec wrap", 8'h00); rd(3'd1, "R2 min wrap", 8'h00); rd(3'd2, "R2 hour carry", 8'h11);
  endtask

  task automatic t_binary();
    fmt_bin = 1'b1; hour24 = 1'b1;
    set_hms(8'h16, 8'h3B, 8'h3A);
    do_tick();
    rd(3'd0, "R4 bin sec", 8'h3B);
    do_tick();
    rd(3'd0, "R4 bin sec wrap", 8'h00); rd(3'd1, "R4 bin min", 8'h00); rd(3'd2, "R4 bin hour", 8'h17);
    fmt_bin = 1'b0;
  endtask

  task automatic t_midnight();
    set_date(8'h07, 8'h10, 8'h05, 8'h24);
    set_hms(8'h23, 8'h59, 8'h59);
    do_tick();
    rd(3'd2, "R5 hour 00", 8'h00); rd(3'd3, "R5 wday wrap", 8'h01); rd(3'd4, "R5 mday", 8'h11);
  endtask

  task automatic t_12h();
    hour24 = 1'b0;
    set_hms(8'h11, 8'h59, 8'h59);
    do_tick();
    rd(3'd2, "R6 noon", 8'h92);
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    do_tick();
    rd(3'd2, "R6 1pm", 8'h81);
    set_hms(8'h91, 8'h59, 8'h59);
    do_tick();
    rd(3'd2, "R6 midnight", 8'h12);
    hour24 = 1'b1;
  endtask

  task automatic t_months();
    set_date(8'h03, 8'h30, 8'h04, 8'h99);
    set_hms(8'h23, 8'h59, 8'h59);
    do_tick();
    rd(3'd4, "R7 30-day mday", 8'h01); rd(3'd5, "R7 30-day mon", 8'h05);
    set_date(8'h03, 8'h31, 8'h12, 8'h99);
    set_hms(8'h23, 8'h59, 8'h59);
    do_tick();
    rd(3'd4, "R7 dec mday", 8'h01); rd(3'd5, "R7 dec mon", 8'h01); rd(3'd6, "R7 year wrap", 8'h00);
  endtask

  task automatic t_leap();
    set_date(8'h02, 8'h28, 8'h02, 8'h24);
    set_hms(8'h23, 8'h59, 8'h59);
    do_tick();
    rd(3'd4, "R8 leap 29", 8'h29); rd(3'd5, "R8 leap feb", 8'h02);
    set_hms(8'h23, 8'h59, 8'h59);
    do_tick();
    rd(3'd4, "R8 leap mar1", 8'h01); rd(3'd5, "R8 leap mar", 8'h03);
    set_date(8'h02, 8'h28, 8'h02, 8'h23);
    set_hms(8'h23, 8'h59, 8'h59);
    do_tick();
    rd(3'd4, "R8 common mar1", 8'h01); rd(3'd5, "R8 common mar", 8'h03);
  endtask

  task automatic t_inhibit();
    set_hms(8'h05, 8'h20, 8'h10);
    inhibit = 1'b1;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    chk("R10 uip forced low", {7'd0, uip}, 8'h00);
    repeat (LEAD) @(negedge clk);
    rd(3'd0, "R9 frozen", 8'h10);
    do_tick();
    rd(3'd0, "R9 still frozen", 8'h10);
    inhibit = 1'b0;
    do_tick();
    rd(3'd0, "R9 resumed", 8'h13);
  endtask

  task automatic t_dst();
    dst_en = 1'b1; hour24 = 1'b1;
    set_date(8'h01, 8'h05, 8'h04, 8'h24);
    set_hms(8'h01, 8'h59, 8'h59);
    do_tick();
    rd(3'd2, "R11 spring hour", 8'h03); rd(3'd1, "R11 spring min", 8'h00);
    set_date(8'h01, 8'h27, 8'h10, 8'h24);
    set_hms(8'h01, 8'h59, 8'h59);
    do_tick();
    rd(3'd2, "R12 fall back", 8'h01); rd(3'd1, "R12 fall min", 8'h00);
    wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    do_tick();
    rd(3'd2, "R12 second pass", 8'h02);
    dst_en = 1'b0;
    set_date(8'h01, 8'h05, 8'h04, 8'h24);
    set_hms(8'h01, 8'h59, 8'h59);
    do_tick();
    rd(3'd2, "R13 no jump", 8'h02);
  endtask

  task automatic t_write();
    fmt_bin = 1'b0;
    wr(3'd0, 8'h45);
    rd(3'd0, "R14 readback", 8'h45);
    fmt_bin = 1'b1;
    do_tick();
    rd(3'd0, "R14 decoded", 8'h2E);
    fmt_bin = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_strobes();
    t_carry();
    t_binary();
    t_midnight();
    t_12h();
    t_months();
    t_leap();
    t_inhibit();
    t_dst();
    t_write();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule